// File: doc/BRIEF.md
# DDS serial control-word receiver

This block is the receiving end of a three-wire serial link that configures a direct digital synthesizer. A host moves an active-low frame strobe low, then sends 16 data bits most significant first, each one sampled when the serial clock falls. Every finished word goes into a small register file. The file holds two 28-bit tuning words, two 12-bit phase offsets and a 14-bit control word. The synthesizer core reads these values directly from the outputs.

The two top bits of each word choose its destination. One control bit selects a paired-write mode. In that mode a tuning word is built from two successive 14-bit writes, the low half first and the high half second. With the mode off, a second control bit picks which half a single write replaces. The serial pins are brought into the system clock domain through a synchronizer, and their edges are detected there. The system clock therefore has to run at least four times faster than the serial clock.

Top module: `dds_ctrl_rx`

## Requirements
- R1: Data is sampled on each falling edge of the serial clock while the frame strobe is low, most significant bit first. Falling edges while the strobe is high are ignored. A falling clock edge that arrives in the same cycle as the strobe's falling edge counts as the first bit.
- R2: A word is complete at the 16th accepted falling edge of a frame. Any further falling edges before the strobe rises are ignored and give no second word.
- R3: If the strobe rises before 16 bits have arrived, the partial word is dropped. No register changes, no strobe pulse is issued, and the paired-write pointer keeps its value.
- R4: A word with bits [15:14] = 00 is a control word, and its bits [13:0] replace `ctrl_o`. Control bit 13 enables the paired-write mode. Control bit 12 is the half select used when paired writes are off. Control bit 8 drives `reset_flag_o`. 0x2100 sets the flag and 0x2000 clears it.
- R5: A word with bits [15:14] = 01 writes tuning word 0, and a word with 10 writes tuning word 1. In both cases the payload is bits [13:0].
- R6: With paired writes on, tuning-word writes alternate between the low half [13:0] and the high half [27:14], starting with the low half. One pointer is shared by both tuning words.
- R7: With paired writes off, a tuning-word write replaces the high half if control bit 12 is 1 and the low half if it is 0. The other half keeps its value.
- R8: A word with bits [15:13] = 110 writes bits [11:0] into phase 0. A word with bits [15:13] = 111 writes them into phase 1.
- R9: A control word that changes bit 13 resets the paired-write pointer to the low half. A control word that leaves bit 13 unchanged keeps the pointer.
- R10: `word_stb_o` pulses for exactly one cycle for each completed word. The register outputs take their new values in that same cycle, which is the 4th system clock edge after the 16th falling edge reaches the pin.
- R11: A synchronous active-high reset clears every register output and the flag, and sets the pointer to the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_i | input | 1 | Serial clock from the host, idles high |
| sdata_i | input | 1 | Serial data from the host |
| fsync_n_i | input | 1 | Active-low frame strobe |
| freq0_o | output | 28 | Tuning word 0 |
| freq1_o | output | 28 | Tuning word 1 |
| phase0_o | output | 12 | Phase offset 0 |
| phase1_o | output | 12 | Phase offset 1 |
| ctrl_o | output | 14 | Last control word payload |
| reset_flag_o | output | 1 | Control bit 8 |
| word_stb_o | output | 1 | One-cycle pulse per completed word |

## Verification
The bench aims at the frame edges. In one case the strobe falls together with the first clock edge, and a design that missed it would shift the word by one bit. In another, extra clocks follow the 16th bit, which a design without a saturating counter would turn into a second corrupted word. A frame cut short in the middle of a paired write would, if handled wrongly, either commit garbage or move the half pointer. The bench also resends a control word with the same mode, and then one that flips the mode, so that a pointer cleared on every control word, or never cleared, writes the wrong half.

// File: rtl/dds_rx_pkg.sv
package dds_rx_pkg;
  // Destination coded in the two top bits of every word
  typedef enum logic [1:0] {
    TGT_CTRL  = 2'b00,
    TGT_FREQ0 = 2'b01,
    TGT_FREQ1 = 2'b10,
    TGT_PHASE = 2'b11
  } tgt_e;
endpackage

// File: rtl/dds_rx_sync.sv
module dds_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '1;
          else     pipe[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '1;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign level_o = pipe[STAGES-1];
endmodule

// File: rtl/dds_rx_shifter.sv
module dds_rx_shifter #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              sdata_i,
  input  logic              fsync_n_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sck_last;
  logic              sck_fall;
  logic              take;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_next;

  always_comb begin
    sck_fall = sck_last && !sck_i;
    take     = sck_fall && !fsync_n_i && (cnt_q < FULL);
    sh_next  = {sh_q[WORD_W-2:0], sdata_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_last <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '0;
      word_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      sck_last <= sck_i;
      valid_o  <= 1'b0;
      if (fsync_n_i) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q  <= sh_next;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          word_o  <= sh_next;
          valid_o <= 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dds_rx_regs.sv
module dds_rx_regs
  import dds_rx_pkg::*;
#(
  parameter int FHALF_W   = 14,
  parameter int PHASE_W   = 12,
  parameter int RESET_BIT = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [FHALF_W+1:0]   word_i,
  input  logic                 valid_i,
  output logic [2*FHALF_W-1:0] freq0_o,
  output logic [2*FHALF_W-1:0] freq1_o,
  output logic [PHASE_W-1:0]   phase0_o,
  output logic [PHASE_W-1:0]   phase1_o,
  output logic [FHALF_W-1:0]   ctrl_o,
  output logic                 reset_flag_o,
  output logic                 strobe_o
);
  localparam int WORD_W    = FHALF_W + 2;
  localparam int PAIR_BIT  = FHALF_W - 1;
  localparam int UPPER_BIT = FHALF_W - 2;
  localparam int PSEL_BIT  = FHALF_W - 1;

  tgt_e               tgt;
  logic [FHALF_W-1:0] data;
  logic [FHALF_W-1:0] ctrl_q;
  logic               pend_q;
  logic               hi_sel;

  logic [FHALF_W-1:0] lo_q [2];
  logic [FHALF_W-1:0] hi_q [2];
  logic [PHASE_W-1:0] ph_q [2];

  always_comb begin
    tgt    = tgt_e'(word_i[WORD_W-1 -: 2]);
    data   = word_i[FHALF_W-1:0];
    hi_sel = ctrl_q[PAIR_BIT] ? pend_q : ctrl_q[UPPER_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      pend_q   <= 1'b0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= valid_i;
      if (valid_i) begin
        unique case (tgt)
          TGT_CTRL: begin
            ctrl_q <= data;
            if (data[PAIR_BIT] != ctrl_q[PAIR_BIT]) pend_q <= 1'b0;
          end
          TGT_FREQ0, TGT_FREQ1: begin
            if (ctrl_q[PAIR_BIT]) pend_q <= !pend_q;
          end
          default: ;
        endcase
      end
    end
  end

  genvar i;
  generate
    for (i = 0; i < 2; i++) begin : g_freq
      localparam tgt_e MINE = (i == 0) ? TGT_FREQ0 : TGT_FREQ1;
      logic hit;
      assign hit = valid_i && (tgt == MINE);
      always_ff @(posedge clk) begin
        if (rst) begin
          lo_q[i] <= '0;
          hi_q[i] <= '0;
        end else if (hit) begin
          if (hi_sel) hi_q[i] <= data;
          else        lo_q[i] <= data;
        end
      end
    end

    for (i = 0; i < 2; i++) begin : g_phase
      logic hit;
      assign hit = valid_i && (tgt == TGT_PHASE) && (word_i[PSEL_BIT] == 1'(i));
      always_ff @(posedge clk) begin
        if (rst)      ph_q[i] <= '0;
        else if (hit) ph_q[i] <= word_i[PHASE_W-1:0];
      end
    end
  endgenerate

  assign freq0_o      = {hi_q[0], lo_q[0]};
  assign freq1_o      = {hi_q[1], lo_q[1]};
  assign phase0_o     = ph_q[0];
  assign phase1_o     = ph_q[1];
  assign ctrl_o       = ctrl_q;
  assign reset_flag_o = ctrl_q[RESET_BIT];
endmodule

// File: rtl/dds_ctrl_rx.sv
module dds_ctrl_rx #(
  parameter int FHALF_W     = 14,
  parameter int PHASE_W     = 12,
  parameter int RESET_BIT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sck_i,
  input  logic                 sdata_i,
  input  logic                 fsync_n_i,
  output logic [2*FHALF_W-1:0] freq0_o,
  output logic [2*FHALF_W-1:0] freq1_o,
  output logic [PHASE_W-1:0]   phase0_o,
  output logic [PHASE_W-1:0]   phase1_o,
  output logic [FHALF_W-1:0]   ctrl_o,
  output logic                 reset_flag_o,
  output logic                 word_stb_o
);
  localparam int WORD_W = FHALF_W + 2;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word_w;
  logic              word_valid;
  logic [CNT_W-1:0]  bit_cnt;

  dds_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({fsync_n_i, sdata_i, sck_i}),
    .level_o (pins_s)
  );

  dds_rx_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sck_i     (pins_s[0]),
    .sdata_i   (pins_s[1]),
    .fsync_n_i (pins_s[2]),
    .word_o    (word_w),
    .valid_o   (word_valid),
    .cnt_o     (bit_cnt)
  );

  dds_rx_regs #(.FHALF_W(FHALF_W), .PHASE_W(PHASE_W), .RESET_BIT(RESET_BIT)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .word_i       (word_w),
    .valid_i      (word_valid),
    .freq0_o      (freq0_o),
    .freq1_o      (freq1_o),
    .phase0_o     (phase0_o),
    .phase1_o     (phase1_o),
    .ctrl_o       (ctrl_o),
    .reset_flag_o (reset_flag_o),
    .strobe_o     (word_stb_o)
  );
endmodule

// File: rtl/dds_ctrl_rx_chk.sv
module dds_ctrl_rx_chk #(
  parameter int FHALF_W = 14,
  parameter int PHASE_W = 12,
  parameter int CNT_W   = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 word_stb_o,
  input logic                 word_valid,
  input logic [CNT_W-1:0]     bit_cnt,
  input logic [2*FHALF_W-1:0] freq0_o,
  input logic [2*FHALF_W-1:0] freq1_o,
  input logic [PHASE_W-1:0]   phase0_o,
  input logic [PHASE_W-1:0]   phase1_o,
  input logic [FHALF_W-1:0]   ctrl_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FHALF_W + 2);

  assert_bit_count_R2: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= FULL);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    word_stb_o |=> !word_stb_o);

  assert_valid_to_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> word_stb_o);

  assert_freq_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !word_stb_o |-> ($stable(freq0_o) && $stable(freq1_o)));

  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !word_stb_o |-> ($stable(phase0_o) && $stable(phase1_o)));

  assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !word_stb_o |-> $stable(ctrl_o));
endmodule

bind dds_ctrl_rx dds_ctrl_rx_chk #(
  .FHALF_W (FHALF_W),
  .PHASE_W (PHASE_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_stb_o (word_stb_o),
  .word_valid (word_valid),
  .bit_cnt    (bit_cnt),
  .freq0_o    (freq0_o),
  .freq1_o    (freq1_o),
  .phase0_o   (phase0_o),
  .phase1_o   (phase1_o),
  .ctrl_o     (ctrl_o)
);

// File: tb/dds_ctrl_rx_test.sv
`timescale 1ns/1ps
module dds_ctrl_rx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b1;
  logic sdata = 1'b1;
  logic fsync_n = 1'b1;
  logic [27:0] freq0, freq1;
  logic [11:0] phase0, phase1;
  logic [13:0] ctrl;
  logic rflag, stb;

  int total = 0;
  int bad = 0;
  bit settle = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  logic [27:0] m_f0 = '0, m_f1 = '0;
  logic [11:0] m_p0 = '0, m_p1 = '0;
  logic [13:0] m_ctrl = '0;
  bit m_pend = 1'b0;

  always #5 clk = ~clk;

  dds_ctrl_rx uut (
    .clk(clk), .rst(rst), .sck_i(sck), .sdata_i(sdata), .fsync_n_i(fsync_n),
    .freq0_o(freq0), .freq1_o(freq1), .phase0_o(phase0), .phase1_o(phase1),
    .ctrl_o(ctrl), .reset_flag_o(rflag), .word_stb_o(stb)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_apply(input logic [15:0] w);
    bit upper;
    case (w[15:14])
      2'b00: begin
        if (w[13] != m_ctrl[13]) m_pend = 1'b0;
        m_ctrl = w[13:0];
      end
      2'b01, 2'b10: begin
        upper = m_ctrl[13] ? m_pend : m_ctrl[12];
        if (w[15:14] == 2'b01) begin
          if (upper) m_f0[27:14] = w[13:0]; else m_f0[13:0] = w[13:0];
        end else begin
          if (upper) m_f1[27:14] = w[13:0]; else m_f1[13:0] = w[13:0];
        end
        if (m_ctrl[13]) m_pend = !m_pend;
      end
      default: begin
        if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
      end
    endcase
  endtask

  // R10: strobe exactly at the 4th sample after the last falling edge
  task automatic watch_latency(input logic [15:0] w);
    int hits = 0;
    int at = -1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (stb) begin hits++; at = k; end
    end
    check(hits == 1 && at == 4, "R10", "strobe position", at, 4);
    model_apply(w);
    settle = 1'b0;
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input bit aligned, input int extra);
    sck = 1'b1; sdata = w[15]; fsync_n = 1'b1;
    wait_clk(4);
    fsync_n = 1'b0;
    if (!aligned) wait_clk(4);
    for (int b = 0; b < nbits; b++) begin
      if (b > 0) begin
        sck = 1'b1; sdata = w[15-b];
        wait_clk(4);
      end
      if (b == 15) begin
        settle = 1'b1; sck = 1'b0;
        watch_latency(w);
      end else begin
        sck = 1'b0;
        wait_clk(4);
      end
    end
    for (int e = 0; e < extra; e++) begin
      sck = 1'b1; sdata = ~sdata; wait_clk(4);
      sck = 1'b0; wait_clk(4);
    end
    sck = 1'b1; wait_clk(4);
    fsync_n = 1'b1; wait_clk(4);
  endtask

  task automatic word(input logic [15:0] w);
    send(w, 16, 1'b0, 0);
  endtask

  // clock-by-clock comparison against the model
  initial begin
    forever begin
      @(posedge clk); #2;
      if (!rst && !settle && !done) begin
        check(freq0 == m_f0 && freq1 == m_f1, "R5", "tuning words vs model",
              {4'h0, freq0}, {4'h0, m_f0});
        check(phase0 == m_p0 && phase1 == m_p1, "R8", "phases vs model",
              {phase1, phase0}, {m_p1, m_p0});
        check(ctrl == m_ctrl && rflag == m_ctrl[8], "R4", "control vs model",
              {rflag, ctrl}, {m_ctrl[8], m_ctrl});
        check(stb == 1'b0, "R10", "no strobe outside a word", stb, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    // R11 reset state
    check(freq0 == 0 && freq1 == 0, "R11", "tuning words after reset", freq0, 0);
    check(phase0 == 0 && phase1 == 0 && ctrl == 0 && !rflag && !stb, "R11",
          "other outputs after reset", {phase1, phase0}, 0);

    // R1: stray clocks with the strobe high are ignored
    for (int k = 0; k < 5; k++) begin
      sck = 1'b0; wait_clk(4); sck = 1'b1; wait_clk(4);
    end
    check(ctrl == 0 && freq0 == 0, "R1", "clocks with strobe high ignored", ctrl, 0);

    word(16'h2100);
    check(rflag == 1'b1 && ctrl == 14'h2100, "R4", "reset flag set", ctrl, 14'h2100);
    word(16'h69F1);
    word(16'h4123);
    check(freq0 == 28'h048E9F1, "R6", "paired write low then high", freq0, 28'h048E9F1);
    word(16'hCABC);
    check(phase0 == 12'hABC, "R8", "phase 0 write", phase0, 12'hABC);
    word(16'hE123);
    check(phase1 == 12'h123, "R8", "phase 1 write", phase1, 12'h123);
    word(16'h2000);
    check(rflag == 1'b0, "R4", "reset flag cleared", rflag, 0);
    word(16'h8005);
    word(16'hBFFF);
    check(freq1 == 28'hFFFC005, "R5", "tuning word 1 paired", freq1, 28'hFFFC005);

    // R3: abort between the two halves
    word(16'h4001);
    send(16'h7FFF, 10, 1'b0, 0);
    check(freq0[13:0] == 14'h0001, "R3", "aborted frame leaves register", freq0, 28'h0);
    word(16'h7FFF);
    check(freq0 == 28'hFFFC001, "R3", "pointer kept across abort", freq0, 28'hFFFC001);

    // R9: mode change clears the pointer, same mode keeps it
    word(16'h4002);
    word(16'h0000);
    word(16'h2000);
    word(16'h4003);
    check(freq0 == 28'hFFFC003, "R9", "pointer cleared by mode change", freq0, 28'hFFFC003);
    word(16'h2000);
    word(16'h4004);
    check(freq0 == 28'h0010003, "R9", "pointer kept by same mode", freq0, 28'h0010003);

    // R7: single writes by half select
    word(16'h1000);
    word(16'h8007);
    check(freq1 == 28'h001C005, "R7", "single write high half", freq1, 28'h001C005);
    word(16'h0000);
    word(16'h8009);
    check(freq1 == 28'h001C009, "R7", "single write low half", freq1, 28'h001C009);

    // R2: extra clocks after the 16th bit
    send(16'hC00F, 16, 1'b0, 4);
    check(phase0 == 12'h00F, "R2", "extra clocks ignored", phase0, 12'h00F);

    // R1: strobe fall together with the first clock fall
    send(16'hE555, 16, 1'b1, 0);
    check(phase1 == 12'h555, "R1", "aligned first bit MSB first", phase1, 12'h555);

    wait_clk(10);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule